// File: doc/BRIEF.md
# Serial Port Receive-FIFO Register Front End

This block is the register-side half of a serial port. A host reaches it over a simple synchronous byte-wide register bus. It holds the mode, baud, control, FIFO-control and port settings and a set of status flags. It also contains a receive queue of configurable depth, 16 entries by default. Bytes from the line side arrive through a valid strobe, and a break event arrives on its own pin. A byte written to the transmit data offset leaves on a one-cycle strobe. The block does not serialize, time or check bits; it only keeps the registers, the flags and the queue.

Read data is combinational in the cycle that the read enable is high. A read's side effects (popping a byte, re-arming the transmit flags) take effect at the clock edge that ends that cycle. The receive interrupt compares the queue fill against a trigger level that software selects. The transmit interrupt output simply reflects a control bit.

Top module: `urf_top`

## Requirements
- R1: After reset, mode reads 0x00, baud 0xFF, control 0x20, port 0x00, FIFO control 0x00 and count 0. Status reads 0x60 (transmit-end and transmit-empty set), and rx_irq, tx_irq and tx_strobe are low.
- R2: The receive queue holds at most 16 bytes and returns them oldest first. A byte arriving while the count at the start of the cycle is 16 is dropped, even if the same cycle pops.
- R3: FIFO control bits 7:6 select the trigger level: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14. The level in force before the write applies. After an accepted byte, receive-full (status bit 1) is set if the new count is at least the trigger level. Reading offset 0x18 returns the code in bits 7:6 and zeros elsewhere.
- R4: A FIFO-control write with bit 1 set empties the queue and clears receive-full. A byte arriving in that cycle is dropped.
- R5: A read of offset 0x14 with a non-empty queue returns the oldest byte and removes it. If the new count is below the trigger level, receive-full is cleared. On an empty queue the read returns 0x00 and changes nothing. Offset 0x1C reads the count.
- R6: Line bytes are accepted only while control bit 4 is 1.
- R7: A write to offset 0x0C clears transmit-empty (status bit 5). On the next cycle tx_strobe is high for one cycle and tx_byte carries the written value.
- R8: Status bits are: 6 transmit-end, 5 transmit-empty, 4 break, 1 receive-full, and bit 0 always 0. A write to offset 0x10 clears each of those flags written as 0 and leaves those written as 1. Sets that happen in the same cycle (a byte arriving, a break) win over these clears.
- R9: A status read while control bit 5 is 1 returns the flags as they were. From the next cycle, transmit-end and transmit-empty are both set.
- R10: Writes are masked as follows: mode with 0x7B, control with 0xFA, port with 0xF3. Baud is stored whole. Offset 0x24 ignores writes and reads 0x00, and any unmapped offset reads 0x00.
- R11: A control write with bit 5 at 0 sets transmit-end. From the next cycle, tx_irq equals the written bit 7.
- R12: rx_irq rises after an accepted byte makes the count reach the trigger level while control bit 6 is 1. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. These clears win over a set in the same cycle.
- R13: A break event sets status bit 4.
- R14: When write and read enables are both high, only the write takes effect and read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Read data, valid in the read cycle, 0 otherwise |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| brk_evt | input | 1 | Break detected on the line |
| tx_strobe | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
Most state in this block can only be seen through a register read. A wrong count, pointer or flag therefore shows up at bus_rdata on the next read of the count, status or receive-data offset. A bad pointer can stay hidden until a pop returns a byte out of order. The interrupt and transmit outputs are registered, so a wrong decision there appears on the port one cycle after the access. The bench compares every port on every cycle, so a divergence is reported within the cycle in which it first becomes observable.

// File: rtl/urf_pkg.sv
`timescale 1ns/1ps
package urf_pkg;

    localparam int unsigned BUS_AW = 6;
    localparam int unsigned BUS_DW = 8;

    // Register offsets
    localparam logic [BUS_AW-1:0] OFS_MODE  = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_BAUD  = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_CTRL  = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_TXD   = 6'h0C;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 6'h10;
    localparam logic [BUS_AW-1:0] OFS_RXD   = 6'h14;
    localparam logic [BUS_AW-1:0] OFS_FCTL  = 6'h18;
    localparam logic [BUS_AW-1:0] OFS_RCNT  = 6'h1C;
    localparam logic [BUS_AW-1:0] OFS_PORT  = 6'h20;
    localparam logic [BUS_AW-1:0] OFS_LSTAT = 6'h24;

    localparam logic [BUS_DW-1:0] MODE_MASK = 8'h7B;
    localparam logic [BUS_DW-1:0] CTRL_MASK = 8'hFA;
    localparam logic [BUS_DW-1:0] PORT_MASK = 8'hF3;
    localparam logic [BUS_DW-1:0] CTRL_RST  = 8'h20;
    localparam logic [BUS_DW-1:0] BAUD_RST  = 8'hFF;

    // Control bits
    localparam int unsigned CB_TXIE = 7;
    localparam int unsigned CB_RXIE = 6;
    localparam int unsigned CB_TXEN = 5;
    localparam int unsigned CB_RXEN = 4;

    // Status bits
    localparam int unsigned SB_TEND = 6;
    localparam int unsigned SB_TDE  = 5;
    localparam int unsigned SB_BRK  = 4;
    localparam int unsigned SB_RDF  = 1;
    localparam int unsigned SB_DR   = 0;

    // FIFO control bits
    localparam int unsigned FB_FLUSH = 1;
    localparam int unsigned FB_TRG_LO = 6;

    typedef enum logic [1:0] {
        TRG_1  = 2'd0,
        TRG_4  = 2'd1,
        TRG_8  = 2'd2,
        TRG_14 = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
    } stat_flags_t;

    localparam stat_flags_t FLAGS_RST = '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0};

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (trig_sel_e'(sel))
            TRG_1:   return 5'd1;
            TRG_4:   return 5'd4;
            TRG_8:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [BUS_DW-1:0] pack_status(input stat_flags_t f);
        logic [BUS_DW-1:0] v;
        v = '0;
        v[SB_TEND] = f.tend;
        v[SB_TDE]  = f.tde;
        v[SB_BRK]  = f.brk;
        v[SB_RDF]  = f.rdf;
        return v;
    endfunction

endpackage

// File: rtl/urf_rx_fifo.sv
`timescale 1ns/1ps
module urf_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             flush,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             push_ok,
    output logic             pop_ok
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Acceptance is judged on the fill at the start of the cycle.
    assign push_ok = push_req && !flush && (count != FULL);
    assign pop_ok  = pop_req  && !flush && (count != '0);

    always_comb begin
        count_next = count;
        if (flush) begin
            count_next = '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count_next = count + 1'b1;
                2'b01:   count_next = count - 1'b1;
                default: count_next = count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    assign dout = (count != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/urf_status.sv
`timescale 1ns/1ps
module urf_status
    import urf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic        wd_txen,
    input  logic        wd_rxie,
    input  logic        stat_wr,
    input  logic        wd_tend,
    input  logic        wd_tde,
    input  logic        wd_brk,
    input  logic        wd_rdf,
    input  logic        wd_dr,
    input  logic        txd_wr,
    input  logic        stat_rd,
    input  logic        tx_en,
    input  logic        rx_ie,
    input  logic        brk_evt,
    input  logic        flush,
    input  logic        rdf_set,
    input  logic        rdf_drop,
    output stat_flags_t flags,
    output logic        rx_irq
);

    stat_flags_t f_d;
    logic        irq_d;
    logic        irq_clr;

    assign irq_clr = (ctrl_wr && !wd_rxie) || (stat_wr && (!wd_rdf || !wd_dr));

    always_comb begin
        f_d = flags;
        // clears first, sets afterwards so that sets win
        if (stat_wr) begin
            if (!wd_tend) f_d.tend = 1'b0;
            if (!wd_tde)  f_d.tde  = 1'b0;
            if (!wd_brk)  f_d.brk  = 1'b0;
            if (!wd_rdf)  f_d.rdf  = 1'b0;
        end
        if (txd_wr)             f_d.tde  = 1'b0;
        if (flush || rdf_drop)  f_d.rdf  = 1'b0;
        if (ctrl_wr && !wd_txen) f_d.tend = 1'b1;
        if (stat_rd && tx_en) begin
            f_d.tend = 1'b1;
            f_d.tde  = 1'b1;
        end
        if (rdf_set) f_d.rdf = 1'b1;
        if (brk_evt) f_d.brk = 1'b1;

        irq_d = rx_irq;
        if (rdf_set && rx_ie) irq_d = 1'b1;
        if (irq_clr)          irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= FLAGS_RST;
            rx_irq <= 1'b0;
        end else begin
            flags  <= f_d;
            rx_irq <= irq_d;
        end
    end

endmodule

// File: rtl/urf_top.sv
`timescale 1ns/1ps
module urf_top
    import urf_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BUS_DW-1:0] rx_byte,
    input  logic              brk_evt,
    output logic              tx_strobe,
    output logic [BUS_DW-1:0] tx_byte,
    output logic              rx_irq,
    output logic              tx_irq
);

    logic [BUS_DW-1:0] mode_q, baud_q, ctrl_q, port_q;
    logic [1:0]        trig_q;

    logic rd;
    logic w_mode, w_baud, w_ctrl, w_txd, w_stat, w_fctl, w_port;
    logic r_stat, r_rxd;
    logic flush;
    logic rx_en;

    assign rd     = bus_re && !bus_we;
    assign w_mode = bus_we && (bus_addr == OFS_MODE);
    assign w_baud = bus_we && (bus_addr == OFS_BAUD);
    assign w_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign w_txd  = bus_we && (bus_addr == OFS_TXD);
    assign w_stat = bus_we && (bus_addr == OFS_STAT);
    assign w_fctl = bus_we && (bus_addr == OFS_FCTL);
    assign w_port = bus_we && (bus_addr == OFS_PORT);
    assign r_stat = rd && (bus_addr == OFS_STAT);
    assign r_rxd  = rd && (bus_addr == OFS_RXD);
    assign flush  = w_fctl && bus_wdata[FB_FLUSH];
    assign rx_en  = ctrl_q[CB_RXEN];

    // Receive queue
    logic [BUS_DW-1:0] rx_head;
    logic [CNT_W-1:0]  rx_cnt, cnt_next;
    logic              push_ok, pop_ok;

    urf_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BUS_DW)
    ) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_req   (rx_valid && rx_en),
        .pop_req    (r_rxd),
        .flush      (flush),
        .din        (rx_byte),
        .dout       (rx_head),
        .count      (rx_cnt),
        .count_next (cnt_next),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    // Trigger comparison uses the level in force before any write this cycle
    logic [4:0] trig_lvl;
    logic       at_trig;
    logic       rdf_set, rdf_drop;

    assign trig_lvl = trig_level(trig_q);
    assign at_trig  = 32'(cnt_next) >= 32'(trig_lvl);
    assign rdf_set  = push_ok && at_trig;
    assign rdf_drop = pop_ok && !at_trig;

    // Status flags and receive interrupt
    stat_flags_t flags_q;

    urf_status u_status (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (w_ctrl),
        .wd_txen  (bus_wdata[CB_TXEN]),
        .wd_rxie  (bus_wdata[CB_RXIE]),
        .stat_wr  (w_stat),
        .wd_tend  (bus_wdata[SB_TEND]),
        .wd_tde   (bus_wdata[SB_TDE]),
        .wd_brk   (bus_wdata[SB_BRK]),
        .wd_rdf   (bus_wdata[SB_RDF]),
        .wd_dr    (bus_wdata[SB_DR]),
        .txd_wr   (w_txd),
        .stat_rd  (r_stat),
        .tx_en    (ctrl_q[CB_TXEN]),
        .rx_ie    (ctrl_q[CB_RXIE]),
        .brk_evt  (brk_evt),
        .flush    (flush),
        .rdf_set  (rdf_set),
        .rdf_drop (rdf_drop),
        .flags    (flags_q),
        .rx_irq   (rx_irq)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            baud_q <= BAUD_RST;
            ctrl_q <= CTRL_RST;
            port_q <= '0;
            trig_q <= TRG_1;
        end else begin
            if (w_mode) mode_q <= bus_wdata & MODE_MASK;
            if (w_baud) baud_q <= bus_wdata;
            if (w_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (w_port) port_q <= bus_wdata & PORT_MASK;
            if (w_fctl) trig_q <= bus_wdata[FB_TRG_LO +: 2];
        end
    end

    // Transmit strobe, one cycle after the data write
    logic              tx_stb_q;
    logic [BUS_DW-1:0] tx_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_stb_q  <= 1'b0;
            tx_byte_q <= '0;
        end else begin
            tx_stb_q <= w_txd;
            if (w_txd) tx_byte_q <= bus_wdata;
        end
    end

    assign tx_strobe = tx_stb_q;
    assign tx_byte   = tx_byte_q;
    assign tx_irq    = ctrl_q[CB_TXIE];

    // Read data path
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (bus_addr)
                OFS_MODE: bus_rdata = mode_q;
                OFS_BAUD: bus_rdata = baud_q;
                OFS_CTRL: bus_rdata = ctrl_q;
                OFS_STAT: bus_rdata = pack_status(flags_q);
                OFS_RXD:  bus_rdata = rx_head;
                OFS_FCTL: bus_rdata = {trig_q, 6'b0};
                OFS_RCNT: bus_rdata = BUS_DW'(rx_cnt);
                OFS_PORT: bus_rdata = port_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/urf_checker.sv
`timescale 1ns/1ps
module urf_checker
    import urf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_re,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              rx_en,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              rdf,
    input logic              tde,
    input logic              tx_strobe,
    input logic [BUS_DW-1:0] tx_byte,
    input logic              tx_irq,
    input logic              rx_irq
);

    logic pop_cyc, flush_cyc;
    assign pop_cyc   = bus_re && !bus_we && (bus_addr == OFS_RXD);
    assign flush_cyc = bus_we && (bus_addr == OFS_FCTL) && bus_wdata[FB_FLUSH];

    // R2: fill never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        32'(rx_cnt) <= DEPTH);

    // R2: a full queue stays full unless popped or flushed
    a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
        (32'(rx_cnt) == DEPTH && !pop_cyc && !flush_cyc) |=> (32'(rx_cnt) == DEPTH));

    // R4: flush empties the queue and drops receive-full
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_cyc |=> (rx_cnt == '0 && !rdf));

    // R5: reading an empty queue without an arriving byte leaves it empty
    a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
        (pop_cyc && rx_cnt == '0 && !(rx_valid && rx_en)) |=> (rx_cnt == '0));

    // R7: data write produces a strobe with that byte and clears transmit-empty
    a_r7_tx_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_TXD) |=> (tx_strobe && tx_byte == $past(bus_wdata) && !tde));

    // R7: no strobe without a data write in the previous cycle
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_TXD) |=> !tx_strobe);

    // R11: transmit interrupt follows written control bit 7
    a_r11_tx_irq: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CTRL) |=> (tx_irq == $past(bus_wdata[CB_TXIE])));

    // R12: clearing writes drop the receive interrupt
    a_r12_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ((bus_addr == OFS_CTRL && !bus_wdata[CB_RXIE]) ||
                    (bus_addr == OFS_STAT && (!bus_wdata[SB_RDF] || !bus_wdata[SB_DR]))))
        |=> !rx_irq);

endmodule

bind urf_top urf_checker #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_en     (rx_en),
    .rx_cnt    (rx_cnt),
    .rdf       (flags_q.rdf),
    .tde       (flags_q.tde),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq)
);

// File: tb/tb_urf_top.sv
`timescale 1ns/1ps
module tb_urf_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       brk_evt = 1'b0;
    logic       tx_strobe;
    logic [7:0] tx_byte;
    logic       rx_irq;
    logic       tx_irq;

    always #2.5 clk = ~clk;

    urf_top dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .brk_evt   (brk_evt),
        .tx_strobe (tx_strobe),
        .tx_byte   (tx_byte),
        .rx_irq    (rx_irq),
        .tx_irq    (tx_irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int         m_mode, m_baud, m_ctrl, m_port, m_trig;
    bit         m_tend, m_tde, m_brk, m_rdf, m_irq, m_txs;
    int         m_txb;
    logic [7:0] q[$];

    function automatic int lvl(int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_baud = 8'hFF; m_ctrl = 8'h20; m_port = 0; m_trig = 0;
        m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_irq = 0;
        m_txs = 0; m_txb = 0;
        q.delete();
    endtask

    function automatic int exp_rdata();
        int st;
        if (!(bus_re && !bus_we)) return 0;
        st = (int'(m_tend) << 6) | (int'(m_tde) << 5) | (int'(m_brk) << 4) | (int'(m_rdf) << 1);
        case (bus_addr)
            6'h00: return m_mode;
            6'h04: return m_baud;
            6'h08: return m_ctrl;
            6'h10: return st;
            6'h14: return (q.size() > 0) ? int'(q[0]) : 0;
            6'h18: return m_trig << 6;
            6'h1C: return q.size();
            6'h20: return m_port;
            default: return 0;
        endcase
    endfunction

    task automatic model_tick();
        bit w, r, fl, push, pop;
        int a, d, trg, n;
        w  = bus_we;
        r  = bus_re && !bus_we;
        a  = int'(bus_addr);
        d  = int'(bus_wdata);
        fl = w && a == 8'h18 && d[1];
        trg  = lvl(m_trig);
        push = rx_valid && m_ctrl[4] && !fl && q.size() < 16;
        pop  = r && a == 8'h14 && q.size() > 0;
        n    = q.size() + int'(push) - int'(pop);
        // receive-full and receive interrupt
        if (fl) m_rdf = 0;
        if (w && a == 8'h10 && !d[1]) m_rdf = 0;
        if (push && n >= trg) m_rdf = 1;
        else if (pop && n < trg) m_rdf = 0;
        if (push && n >= trg && m_ctrl[6]) m_irq = 1;
        if (w && a == 8'h08 && !d[6]) m_irq = 0;
        if (w && a == 8'h10 && (!d[1] || !d[0])) m_irq = 0;
        // transmit flags and break
        if (w && a == 8'h10) begin
            if (!d[6]) m_tend = 0;
            if (!d[5]) m_tde = 0;
            if (!d[4]) m_brk = 0;
        end
        if (w && a == 8'h0C) m_tde = 0;
        if (w && a == 8'h08 && !d[5]) m_tend = 1;
        if (r && a == 8'h10 && m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
        if (brk_evt) m_brk = 1;
        m_txs = w && a == 8'h0C;
        if (m_txs) m_txb = d;
        // queue
        if (fl) q.delete();
        else begin
            if (pop) void'(q.pop_front());
            if (push) q.push_back(rx_byte);
        end
        // registers
        if (w) begin
            case (a)
                8'h00: m_mode = d & 8'h7B;
                8'h04: m_baud = d;
                8'h08: m_ctrl = d & 8'hFA;
                8'h18: m_trig = (d >> 6) & 3;
                8'h20: m_port = d & 8'hF3;
                default: ;
            endcase
        end
    endtask

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit we, bit re, logic [5:0] a, logic [7:0] d, bit rv, logic [7:0] rb, bit bk);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_byte = rb; brk_evt = bk;
        #1;
        check("bus_rdata", int'(bus_rdata), exp_rdata());
        @(posedge clk);
        model_tick();
        #1;
        check("tx_strobe", int'(tx_strobe), int'(m_txs));
        check("tx_byte", int'(tx_byte), m_txb);
        check("rx_irq", int'(rx_irq), int'(m_irq));
        check("tx_irq", int'(tx_irq), int'(m_ctrl[7]));
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d); step(1, 0, a, d, 0, 0, 0); endtask
    task automatic rd(logic [5:0] a);                step(0, 1, a, 0, 0, 0, 0); endtask
    task automatic rx(logic [7:0] b);                step(0, 0, 0, 0, 1, b, 0); endtask
    task automatic idle();                           step(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every offset
        cur_req = "R1";
        foreach (q[i]) ;
        for (int o = 0; o < 16; o++) rd(6'(o * 4));

        // R10: masks, readback, ignored and unmapped offsets
        cur_req = "R10";
        wr(6'h00, 8'hFF); rd(6'h00);
        wr(6'h04, 8'h5A); rd(6'h04);
        wr(6'h20, 8'hFF); rd(6'h20);
        wr(6'h24, 8'hFF); rd(6'h24);
        rd(6'h28); rd(6'h3C); rd(6'h02); rd(6'h13);

        // R11: control write, transmit-end set, tx_irq follows bit 7
        cur_req = "R11";
        wr(6'h10, 8'h00); rd(6'h10);
        wr(6'h08, 8'hFF); rd(6'h08); rd(6'h10);
        wr(6'h08, 8'h80); rd(6'h10);
        wr(6'h08, 8'h00); idle();

        // R6: receive disabled drops bytes
        cur_req = "R6";
        rx(8'h11); rx(8'h22); rd(6'h1C); rd(6'h14);

        // R3: trigger levels and receive-full
        cur_req = "R3";
        wr(6'h08, 8'h50);
        for (int c = 0; c < 4; c++) begin
            wr(6'h18, 8'((c << 6) | 2));
            rd(6'h18);
            for (int k = 0; k < 15; k++) begin
                rx(8'(8'h30 + k));
                rd(6'h10);
            end
            wr(6'h10, 8'hFC); idle();
        end

        // R5: pops in order, count, receive-full drop below trigger, empty read
        cur_req = "R5";
        wr(6'h18, 8'h82);
        for (int k = 0; k < 10; k++) rx(8'(8'hA0 + k));
        for (int k = 0; k < 12; k++) begin
            rd(6'h1C); rd(6'h14); rd(6'h10);
        end
        rd(6'h14); rd(6'h1C);

        // R2: overflow drop, wrap, simultaneous pop at full
        cur_req = "R2";
        wr(6'h18, 8'h02);
        for (int k = 0; k < 20; k++) rx(8'(k + 1));
        rd(6'h1C);
        step(0, 1, 6'h14, 0, 1, 8'hEE, 0);
        rd(6'h1C);
        rx(8'h77); rd(6'h1C);
        for (int k = 0; k < 17; k++) rd(6'h14);

        // R4: flush with data present, byte in same cycle dropped
        cur_req = "R4";
        for (int k = 0; k < 5; k++) rx(8'(8'hC0 + k));
        rd(6'h10);
        step(1, 0, 6'h18, 8'h42, 1, 8'h99, 0);
        rd(6'h1C); rd(6'h10); rd(6'h14); rd(6'h18);

        // R12: interrupt rise and both clear paths
        cur_req = "R12";
        wr(6'h08, 8'h50); wr(6'h18, 8'h00);
        rx(8'h01); idle();
        wr(6'h10, 8'hFE); idle();
        rx(8'h02); idle();
        wr(6'h08, 8'h10); idle();
        wr(6'h08, 8'h50);
        step(1, 0, 6'h10, 8'hFD, 1, 8'h03, 0);
        rd(6'h10);
        step(1, 0, 6'h08, 8'h10, 1, 8'h04, 0);
        wr(6'h18, 8'h02);

        // R8: status clear patterns, set wins over clear
        cur_req = "R8";
        wr(6'h08, 8'h10);
        rx(8'h05); rd(6'h10);
        wr(6'h10, 8'hFF); rd(6'h10);
        wr(6'h10, 8'hBF); rd(6'h10);
        wr(6'h10, 8'hDF); rd(6'h10);
        step(1, 0, 6'h10, 8'h00, 0, 0, 1); rd(6'h10);
        step(1, 0, 6'h10, 8'h00, 1, 8'h06, 0); rd(6'h10);

        // R13: break sets bit 4
        cur_req = "R13";
        wr(6'h10, 8'h00); rd(6'h10);
        step(0, 0, 0, 0, 0, 0, 1); rd(6'h10);

        // R9: status read re-arms transmit flags only with transmit enabled
        cur_req = "R9";
        wr(6'h08, 8'h00); wr(6'h10, 8'h00); rd(6'h10); rd(6'h10);
        wr(6'h08, 8'h30); wr(6'h10, 8'h00); rd(6'h10); rd(6'h10);

        // R7: transmit strobes, back-to-back and spaced
        cur_req = "R7";
        wr(6'h0C, 8'h3C); rd(6'h10);
        wr(6'h0C, 8'hA5); wr(6'h0C, 8'h5A); idle(); idle();

        // R14: write wins when both enables are high
        cur_req = "R14";
        wr(6'h18, 8'h02); rx(8'h44);
        step(1, 1, 6'h14, 8'h00, 0, 0, 0);
        rd(6'h1C);
        step(1, 1, 6'h00, 8'h12, 0, 0, 0);
        rd(6'h00);

        // Mixed traffic, all rules at once
        cur_req = "R2/R3/R5/R8/R12";
        for (int it = 0; it < 5000; it++) begin
            int ofs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};
            int   sel = int'($urandom_range(10, 0));
            bit   we  = ($urandom_range(99, 0) < 20);
            bit   re  = ($urandom_range(99, 0) < 45);
            logic [7:0] d = 8'($urandom);
            if (ofs[sel] == 8'h18 && $urandom_range(3, 0) != 0) d[1] = 1'b0;
            if (ofs[sel] == 8'h08 && $urandom_range(3, 0) != 0) d[4] = 1'b1;
            step(we, re, 6'(ofs[sel]), d, ($urandom_range(99, 0) < 45), 8'($urandom),
                 ($urandom_range(99, 0) < 3));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule